// File: doc/BRIEF.md
# Thermocouple Converter Serial Reader

This block is a serial-bus master that fetches one temperature reading from a read-only thermocouple-to-digital converter. A start pulse, or an internal timer when periodic mode is enabled, causes the block to pull chip select low. It then clocks out 32 serial clock cycles with the most significant bit first and samples the converter's data line on each rising clock edge. The block keeps only the first 14 bits it receives and drops the remaining 18.

The 14-bit field is a two's-complement number in quarter-degree steps. The block publishes it in three forms: sign-extended to 16 bits, which equals the temperature times four; a signed whole-degree part; and a two-bit count of quarter degrees. All three registers update together, and a one-cycle valid strobe marks the update. A busy flag covers the whole transaction, including the quiet time with chip select high that follows every frame.

The controller has four named states. IDLE is the rest state with chip select high. SETUP holds chip select low for half a clock period before the first edge. SHIFT produces the 32 serial clock cycles. GAP holds chip select high for one full clock period. The transitions are: IDLE to SETUP on an accepted trigger; SETUP to SHIFT after one half period; SHIFT to GAP on the falling edge of the 32nd clock; GAP back to IDLE after two half periods, which is also when the results load and valid is raised.

Top module: `tc_spi_reader`

## Requirements
- R1: While reset is held and afterwards until the first trigger, cs_n_o is 1, sck_o is 0, busy_o and valid_o are 0, and all result outputs are 0.
- R2: An accepted trigger drives cs_n_o low. Exactly 32 rising edges of sck_o then occur while cs_n_o is low. sck_o is low whenever cs_n_o is high.
- R3: One sck_o period is 2*HALF_PERIOD clock cycles (10 cycles by default, which is 5 MHz from a 50 MHz clock). miso_i is sampled when sck_o rises, and the bits arrive most significant first.
- R4: temp_q_o holds frame bits 31:18 (bit 31 is the sign) as a two's-complement value sign-extended to 16 bits, so it equals the temperature times 4 (-121.5 degrees reads as -486). Frame bits 17:0 have no effect.
- R5: temp_whole_o equals frame bits 31:20 read as a signed number, which is the floor of the temperature. temp_frac_o equals frame bits 19:18, counted in quarter degrees to be added to that floor.
- R6: valid_o pulses for exactly one cycle, 67*HALF_PERIOD cycles after the clock edge that accepts the trigger. The result outputs change only together with that pulse.
- R7: busy_o rises on the same edge at which cs_n_o falls, stays high until valid_o is raised, and is low in the cycle valid_o is high.
- R8: A trigger that arrives while busy_o is high is ignored. The frame in progress still produces exactly 32 clocks and one valid pulse, and no further frame follows it.
- R9: Between two frames, cs_n_o stays high for at least 2*HALF_PERIOD cycles.
- R10: While periodic_en_i is high, a trigger is raised every period_i cycles. When the block is idle at each trigger, successive falls of cs_n_o are exactly period_i cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one reading |
| periodic_en_i | input | 1 | Enable the interval timer |
| period_i | input | 24 | Timer interval in clock cycles |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock, idles low |
| busy_o | output | 1 | Transaction in progress |
| valid_o | output | 1 | One-cycle result strobe |
| temp_q_o | output | 16 | Signed temperature in quarter degrees |
| temp_whole_o | output | 12 | Signed whole-degree part (floor) |
| temp_frac_o | output | 2 | Quarter-degree remainder |

## Verification
The edge that accepts start_i is counted as edge zero. cs_n_o and busy_o change right after it. valid_o and the results appear after edge 67*HALF_PERIOD: 335 with the defaults, made up of 5 setup cycles, 320 shift cycles and 10 gap cycles. The bench drives inputs on falling clock edges and then counts rising edges one at a time, reading the outputs on each following falling edge, so the arrival cycle is checked exactly rather than within a window. It counts serial clock edges and measures their spacing and the chip-select gaps from monitors that timestamp transitions against a cycle counter. It reads each result both in its strobe cycle and in the cycle after, to confirm that the value holds.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } tc_state_e;
endpackage

// File: rtl/tc_clk_div.sv
module tc_clk_div #(
    parameter int HALF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!en || tick) cnt <= '0;
        else                 cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/tc_capture.sv
module tc_capture #(
    parameter int FIELD_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               sample,
    input  logic               miso,
    output logic [FIELD_W-1:0] field
);
    localparam int KW = $clog2(FIELD_W + 1);
    localparam logic [KW-1:0] FULL = KW'(FIELD_W);

    logic [KW-1:0] taken;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field <= '0;
            taken <= '0;
        end else if (clear) begin
            taken <= '0;
        end else if (sample && (taken != FULL)) begin
            field <= {field[FIELD_W-2:0], miso};
            taken <= taken + KW'(1);
        end
    end
endmodule

// File: rtl/tc_period_trig.sv
module tc_period_trig #(
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] period,
    output logic          pulse
);
    logic [PW-1:0] cnt;
    logic          hit;

    assign hit   = ({1'b0, cnt} + (PW+1)'(1)) >= {1'b0, period};
    assign pulse = en && hit;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!en || hit) cnt <= '0;
        else                 cnt <= cnt + PW'(1);
    end
endmodule

// File: rtl/tc_decode.sv
module tc_decode #(
    parameter int FIELD_W = 14,
    parameter int FRAC_W  = 2,
    parameter int OUT_W   = 16
) (
    input  logic [FIELD_W-1:0]        field,
    output logic [OUT_W-1:0]          temp_q,
    output logic [FIELD_W-FRAC_W-1:0] whole,
    output logic [FRAC_W-1:0]         frac
);
    generate
        if (OUT_W > FIELD_W) begin : g_ext
            assign temp_q = {{(OUT_W-FIELD_W){field[FIELD_W-1]}}, field};
        end else begin : g_trunc
            assign temp_q = field[OUT_W-1:0];
        end
    endgenerate

    assign whole = field[FIELD_W-1:FRAC_W];
    assign frac  = field[FRAC_W-1:0];
endmodule

// File: rtl/tc_spi_reader.sv
module tc_spi_reader
    import tc_pkg::*;
#(
    parameter int HALF_PERIOD = 5,
    parameter int FRAME_BITS  = 32,
    parameter int FIELD_BITS  = 14,
    parameter int FRAC_BITS   = 2,
    parameter int OUT_BITS    = 16,
    parameter int PERIOD_BITS = 24,
    parameter int GAP_HALVES  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic                            periodic_en_i,
    input  logic [PERIOD_BITS-1:0]          period_i,
    input  logic                            miso_i,
    output logic                            cs_n_o,
    output logic                            sck_o,
    output logic                            busy_o,
    output logic                            valid_o,
    output logic [OUT_BITS-1:0]             temp_q_o,
    output logic [FIELD_BITS-FRAC_BITS-1:0] temp_whole_o,
    output logic [FRAC_BITS-1:0]            temp_frac_o
);
    localparam int BIT_W   = $clog2(FRAME_BITS);
    localparam int GAP_W   = $clog2(GAP_HALVES + 1);
    localparam int WHOLE_W = FIELD_BITS - FRAC_BITS;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
    localparam logic [GAP_W-1:0] LAST_GAP = GAP_W'(GAP_HALVES - 1);

    tc_state_e state, state_nx;

    logic                  tick;
    logic                  trig;
    logic                  per_pulse;
    logic                  sck_q;
    logic [BIT_W-1:0]      bit_idx;
    logic [GAP_W-1:0]      gap_cnt;
    logic                  sample;
    logic [FIELD_BITS-1:0] field;
    logic [OUT_BITS-1:0]   dec_q;
    logic [WHOLE_W-1:0]    dec_whole;
    logic [FRAC_BITS-1:0]  dec_frac;
    logic                  div_en;

    assign trig   = start_i || per_pulse;
    assign div_en = (state != ST_IDLE);
    assign sample = (state == ST_SHIFT) && tick && !sck_q;

    tc_clk_div #(.HALF(HALF_PERIOD)) u_div (
        .clk(clk), .rst_n(rst_n), .en(div_en), .tick(tick)
    );

    tc_period_trig #(.PW(PERIOD_BITS)) u_trig (
        .clk(clk), .rst_n(rst_n), .en(periodic_en_i),
        .period(period_i), .pulse(per_pulse)
    );

    tc_capture #(.FIELD_W(FIELD_BITS)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE),
        .sample(sample), .miso(miso_i), .field(field)
    );

    tc_decode #(.FIELD_W(FIELD_BITS), .FRAC_W(FRAC_BITS), .OUT_W(OUT_BITS)) u_dec (
        .field(field), .temp_q(dec_q), .whole(dec_whole), .frac(dec_frac)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (trig) state_nx = ST_SETUP;
            ST_SETUP: if (tick) state_nx = ST_SHIFT;
            ST_SHIFT: if (tick && sck_q && (bit_idx == LAST_BIT)) state_nx = ST_GAP;
            ST_GAP:   if (tick && (gap_cnt == LAST_GAP)) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // serial clock, counters and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q        <= 1'b0;
            bit_idx      <= '0;
            gap_cnt      <= '0;
            valid_o      <= 1'b0;
            temp_q_o     <= '0;
            temp_whole_o <= '0;
            temp_frac_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            unique case (state)
                ST_IDLE, ST_SETUP: begin
                    sck_q   <= 1'b0;
                    bit_idx <= '0;
                    gap_cnt <= '0;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                        end else begin
                            sck_q   <= 1'b0;
                            bit_idx <= bit_idx + BIT_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    sck_q <= 1'b0;
                    if (tick) begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                        if (gap_cnt == LAST_GAP) begin
                            valid_o      <= 1'b1;
                            temp_q_o     <= dec_q;
                            temp_whole_o <= dec_whole;
                            temp_frac_o  <= dec_frac;
                        end
                    end
                end
                default: sck_q <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        sck_o  = sck_q;
        busy_o = (state != ST_IDLE);
        cs_n_o = !((state == ST_SETUP) || (state == ST_SHIFT));
    end
endmodule

// File: rtl/tc_spi_reader_chk.sv
module tc_spi_reader_chk #(
    parameter int HALF_PERIOD = 5,
    parameter int OUT_BITS    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n_o,
    input logic                sck_o,
    input logic                busy_o,
    input logic                valid_o,
    input logic [OUT_BITS-1:0] temp_q_o
);
    localparam int GAP_MIN = 2 * HALF_PERIOD;

    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                  hi_cnt <= 16'hFFFF;
        else if (!cs_n_o)            hi_cnt <= '0;
        else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
    end

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);

    // R7
    busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!busy_o && $past(busy_o)));

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(temp_q_o));

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (int'(hi_cnt) >= GAP_MIN));
endmodule

bind tc_spi_reader tc_spi_reader_chk #(
    .HALF_PERIOD(HALF_PERIOD), .OUT_BITS(OUT_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sck_o(sck_o),
    .busy_o(busy_o), .valid_o(valid_o), .temp_q_o(temp_q_o)
);

// File: tb/tc_spi_reader_tb.sv
module tc_spi_reader_tb;
    localparam int HALF = 5;
    localparam int LAT  = 67 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        periodic_en_i = 1'b0;
    logic [23:0] period_i = 24'd0;
    logic        miso_i = 1'b0;
    logic        cs_n_o, sck_o, busy_o, valid_o;
    logic [15:0] temp_q_o;
    logic [11:0] temp_whole_o;
    logic [1:0]  temp_frac_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    tc_spi_reader u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .periodic_en_i(periodic_en_i),
        .period_i(period_i), .miso_i(miso_i), .cs_n_o(cs_n_o), .sck_o(sck_o),
        .busy_o(busy_o), .valid_o(valid_o), .temp_q_o(temp_q_o),
        .temp_whole_o(temp_whole_o), .temp_frac_o(temp_frac_o)
    );

    always #10 clk = ~clk;

    // converter model
    logic [31:0] frame = 32'd0;
    int bp = 0;
    int sck_rises = 0;
    int last_rise = -1;
    int per_min = 1000000;
    int per_max = 0;
    int vcount = 0;
    int fall_cyc = 0;
    int fall_prev = 0;
    int rise_cyc = 0;
    int last_gap = 0;
    int falls = 0;

    always @(posedge clk) cyc++;
    always @(posedge clk) if (rst_n && valid_o) vcount++;

    always @(negedge cs_n_o) begin
        bp = 31;
        miso_i = frame[31];
        fall_prev = fall_cyc;
        fall_cyc = cyc;
        last_gap = cyc - rise_cyc;
        falls++;
    end
    always @(posedge cs_n_o) rise_cyc = cyc;

    always @(negedge sck_o) begin
        if (cs_n_o === 1'b0) begin
            bp--;
            if (bp >= 0) miso_i = frame[bp];
        end
    end

    always @(posedge sck_o) begin
        if (cs_n_o === 1'b0) begin
            sck_rises++;
            if (last_rise >= 0) begin
                if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                if (cyc - last_rise > per_max) per_max = cyc - last_rise;
            end
            last_rise = cyc;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        finish_run();
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        check("R1 cs_n", int'(cs_n_o), 1);
        check("R1 sck", int'(sck_o), 0);
        check("R1 busy", int'(busy_o), 0);
        check("R1 valid", int'(valid_o), 0);
        check("R1 temp", int'(temp_q_o), 0);
        check("R1 whole/frac", int'({temp_whole_o, temp_frac_o}), 0);
    endtask

    // one reading of quarter-degree value q with filler in the low 18 bits
    task automatic t_read(input int q, input logic [17:0] junk, input string name);
        int k;
        int vb;
        logic [13:0] f;
        f = q[13:0];
        frame = {f, junk};
        sck_rises = 0; last_rise = -1; per_min = 1000000; per_max = 0;
        vb = vcount;
        @(negedge clk) start_i = 1'b1;
        @(posedge clk);
        @(negedge clk) start_i = 1'b0;
        check({"R2 cs low ", name}, int'(cs_n_o), 0);
        check({"R7 busy ", name}, int'(busy_o), 1);
        k = 0;
        while (!valid_o && k < 2000) begin
            @(posedge clk); k++;
            @(negedge clk);
        end
        check({"R6 latency ", name}, k, LAT);
        check({"R7 busy at valid ", name}, int'(busy_o), 0);
        check({"R4 temp_q ", name}, int'($signed(temp_q_o)), q);
        check({"R5 whole ", name}, int'($signed(temp_whole_o)), q >>> 2);
        check({"R5 frac ", name}, int'(temp_frac_o), q & 3);
        check({"R2 sck count ", name}, sck_rises, 32);
        check({"R3 sck period min ", name}, per_min, 2 * HALF);
        check({"R3 sck period max ", name}, per_max, 2 * HALF);
        @(posedge clk);
        @(negedge clk);
        check({"R6 one cycle ", name}, int'(valid_o), 0);
        check({"R6 held ", name}, int'($signed(temp_q_o)), q);
        check({"R6 single pulse ", name}, vcount - vb, 1);
    endtask

    task automatic t_junk_ignored();
        // R4: same field with opposite filler bits gives same result
        t_read(-486, 18'h00000, "m121.5 zero filler");
        t_read(-486, 18'h3FFFF, "m121.5 ones filler");
        t_read(100, 18'h2AAAA, "p25 pattern filler");
    endtask

    task automatic t_ignore_start();
        int vb;
        frame = {14'(12'sd40 * 4), 18'h15555};
        sck_rises = 0;
        vb = vcount;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (50) @(negedge clk);
        start_i = 1'b1;
        repeat (20) @(negedge clk);
        start_i = 1'b0;
        repeat (400) @(negedge clk);
        // R8
        check("R8 sck count", sck_rises, 32);
        check("R8 valid count", vcount - vb, 1);
        check("R8 idle after", int'(cs_n_o), 1);
        check("R8 result", int'($signed(temp_q_o)), 160);
    endtask

    task automatic t_periodic();
        int f0;
        frame = {14'd8, 18'd0};
        period_i = 24'd500;
        f0 = falls;
        @(negedge clk) periodic_en_i = 1'b1;
        while (falls < f0 + 3) @(negedge clk);
        // R10
        check("R10 interval", fall_cyc - fall_prev, 500);
        periodic_en_i = 1'b0;
        while (busy_o) @(negedge clk);
        check("R10 reading", int'($signed(temp_q_o)), 8);
    endtask

    task automatic t_gap();
        int f0;
        frame = {14'h3FFF, 18'd0};
        period_i = 24'd1;
        f0 = falls;
        @(negedge clk) periodic_en_i = 1'b1;
        while (falls < f0 + 2) @(negedge clk);
        // R9
        check("R9 cs gap", (last_gap >= 2 * HALF) ? 1 : 0, 1);
        periodic_en_i = 1'b0;
        while (busy_o) @(negedge clk);
        check("R4 minus quarter", int'($signed(temp_q_o)), -1);
        check("R5 minus quarter frac", int'(temp_frac_o), 3);
    endtask

    initial begin
        t_reset();
        t_junk_ignored();
        t_read(2000, 18'h0F0F0, "p500");
        t_read(-800, 18'h12345, "m200");
        t_read(3, 18'h00001, "p0.75");
        t_read(-1, 18'h3FFFF, "m0.25");
        t_ignore_start();
        t_periodic();
        t_gap();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule